// File: doc/BRIEF.md
# Accumulator ALU with Nibble-Carry Flags

This block is the combinational arithmetic and logic unit of a small accumulator processor. It takes an operation code, the accumulator byte, a second operand byte and the current flag byte. In the same cycle it returns the new accumulator value, the new flag byte and a write strobe for the accumulator. It also holds a 16-bit adder for register pairs, with its own result and its own write strobe.

There are four flags: zero (Z), subtract (N), half-carry (H) and carry (C). H is the carry or borrow across the boundary between the low and high nibble of the byte. Each operation class sets, clears or keeps each flag by its own rule. The core that contains the block fetches the operands, decodes instructions and writes back only when a strobe is high.

Top module: `acc_alu`

## Requirements
- R1: Op 0 (add) and op 1 (add with carry) produce (acc + opnd + cin) mod 256. Z is set when that result is zero and N is cleared. H is the carry out of bit 3 and C is the carry out of bit 7. cin is flag C for op 1 and 0 for op 0.
- R2: Op 2 (subtract) and op 3 (subtract with borrow) produce (acc - opnd - bin) mod 256 and set N. Z is set when the result is zero. C is set when acc < opnd + bin. H is set when acc[3:0] < opnd[3:0] + bin. bin is flag C for op 3 and 0 for op 2.
- R3: For ops 1 and 3, the incoming carry enters both the nibble computation and the byte computation. This includes operand 0xFF with carry 1, which sets both H and C.
- R4: Op 7 (compare) gives the same flags as op 2 with the same operands, and it holds the accumulator write strobe low.
- R5: Op 4 (AND) produces acc & opnd. It sets H, clears N and C, and sets Z on a zero result.
- R6: Op 5 (XOR) and op 6 (OR) produce acc ^ opnd and acc | opnd. They clear N, H and C and set Z on a zero result.
- R7: Op 8 (increment) and op 9 (decrement) produce acc ± 1 mod 256. They set Z and H by the add or subtract rule, set N to 0 for op 8 and 1 for op 9, and pass C through unchanged.
- R8: Op 10 (pair add) produces pair_l + pair_r mod 65536. It clears N, sets H from the carry out of bit 11 and C from the carry out of bit 15, and passes Z through unchanged.
- R9: The flag byte holds Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Output bits 3:0 are always zero.
- R10: Op codes 11 to 15 write nothing: both strobes are low and flag bits 7:4 pass through unchanged.
- R11: acc_we_o is high exactly for ops 0–6, 8 and 9. pair_we_o is high exactly for op 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (see requirements) |
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand byte |
| flags_i | input | 8 | Current flag byte |
| pair_l_i | input | 16 | First register-pair operand |
| pair_r_i | input | 16 | Second register-pair operand |
| acc_o | output | 8 | Byte result (also driven for compare) |
| flags_o | output | 8 | New flag byte |
| acc_we_o | output | 1 | Accumulator write strobe |
| pair_o | output | 16 | Register-pair sum |
| pair_we_o | output | 1 | Register-pair write strobe |

## Verification
The bench sweeps every operand pair for every byte operation and drives both carry values into the carry-consuming operations. This reaches operand 0xFF with carry in, where a design that adds the carry only to the byte sum reports a wrong H. It also reaches equal low nibbles with a borrow in, where a nibble comparison that ignores the borrow clears H when it should set it. It drives random values into the unused flag bits, so an increment that disturbs C, a pair add that disturbs Z, or an unused op code that changes a flag shows up as a flag mismatch. A large pseudo-random sweep of the pair adder catches a half-carry taken from the wrong bit.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int PAIR_W = 16;
  localparam int PAIR_H = 12;

  localparam int FZ = 7;
  localparam int FN = 6;
  localparam int FH = 5;
  localparam int FC = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_OR   = 4'd6,
    OP_CMP  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_PAIR = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_XOR = 2'd1,
    LG_OR  = 2'd2
  } logic_sel_e;
endpackage

// File: rtl/acc_arith.sv
module acc_arith #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         half_o,
  output logic         carry_o
);
  localparam int EXT_L = NIB + 1;
  localparam int EXT_F = W + 1;

  logic [EXT_L-1:0] low_q;
  logic [EXT_F-1:0] full_q;
  logic [EXT_L-1:0] cin_l;
  logic [EXT_F-1:0] cin_f;

  assign cin_l = {{NIB{1'b0}}, cin_i};
  assign cin_f = {{W{1'b0}}, cin_i};

  always_comb begin
    if (sub_i) begin
      low_q  = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]} - cin_l;
      full_q = {1'b0, a_i} - {1'b0, b_i} - cin_f;
    end else begin
      low_q  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + cin_l;
      full_q = {1'b0, a_i} + {1'b0, b_i} + cin_f;
    end
  end

  assign res_o   = full_q[W-1:0];
  assign half_o  = low_q[NIB];
  assign carry_o = full_q[W];
endmodule

// File: rtl/acc_logic.sv
module acc_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i | b_i;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic [3:0]  op_i,
  input  logic [7:0]  acc_i,
  input  logic [7:0]  opnd_i,
  input  logic [7:0]  flags_i,
  input  logic [15:0] pair_l_i,
  input  logic [15:0] pair_r_i,
  output logic [7:0]  acc_o,
  output logic [7:0]  flags_o,
  output logic        acc_we_o,
  output logic [15:0] pair_o,
  output logic        pair_we_o
);
  logic [BYTE_W-1:0] arith_b;
  logic              arith_sub;
  logic              arith_cin;
  logic [BYTE_W-1:0] arith_res;
  logic              arith_h;
  logic              arith_c;
  logic [BYTE_W-1:0] logic_res;
  logic_sel_e        logic_sel;
  logic              pair_h;
  logic              pair_c;
  logic              c_in;
  logic [3:0]        nf;

  assign c_in = flags_i[FC];

  // operand and direction selection for the byte adder
  always_comb begin
    arith_b   = opnd_i;
    arith_sub = 1'b0;
    arith_cin = 1'b0;
    case (op_i)
      OP_ADC: arith_cin = c_in;
      OP_SUB, OP_CMP: arith_sub = 1'b1;
      OP_SBC: begin
        arith_sub = 1'b1;
        arith_cin = c_in;
      end
      OP_INC: arith_b = BYTE_W'(1);
      OP_DEC: begin
        arith_b   = BYTE_W'(1);
        arith_sub = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (op_i)
      OP_XOR:  logic_sel = LG_XOR;
      OP_OR:   logic_sel = LG_OR;
      default: logic_sel = LG_AND;
    endcase
  end

  acc_arith #(.W(BYTE_W), .NIB(NIB_W)) byte_arith_i (
    .a_i     (acc_i),
    .b_i     (arith_b),
    .sub_i   (arith_sub),
    .cin_i   (arith_cin),
    .res_o   (arith_res),
    .half_o  (arith_h),
    .carry_o (arith_c)
  );

  acc_logic #(.W(BYTE_W)) byte_logic_i (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .sel_i (logic_sel),
    .res_o (logic_res)
  );

  acc_arith #(.W(PAIR_W), .NIB(PAIR_H)) pair_arith_i (
    .a_i     (pair_l_i),
    .b_i     (pair_r_i),
    .sub_i   (1'b0),
    .cin_i   (1'b0),
    .res_o   (pair_o),
    .half_o  (pair_h),
    .carry_o (pair_c)
  );

  // result, flag and strobe composition; nf = {Z,N,H,C}
  always_comb begin
    acc_o     = acc_i;
    acc_we_o  = 1'b0;
    pair_we_o = 1'b0;
    nf        = flags_i[7:4];
    case (op_i)
      OP_ADD, OP_ADC: begin
        acc_o    = arith_res;
        acc_we_o = 1'b1;
        nf       = {arith_res == '0, 1'b0, arith_h, arith_c};
      end
      OP_SUB, OP_SBC: begin
        acc_o    = arith_res;
        acc_we_o = 1'b1;
        nf       = {arith_res == '0, 1'b1, arith_h, arith_c};
      end
      OP_CMP: begin
        acc_o = arith_res;
        nf    = {arith_res == '0, 1'b1, arith_h, arith_c};
      end
      OP_AND: begin
        acc_o    = logic_res;
        acc_we_o = 1'b1;
        nf       = {logic_res == '0, 1'b0, 1'b1, 1'b0};
      end
      OP_XOR, OP_OR: begin
        acc_o    = logic_res;
        acc_we_o = 1'b1;
        nf       = {logic_res == '0, 3'b000};
      end
      OP_INC: begin
        acc_o    = arith_res;
        acc_we_o = 1'b1;
        nf       = {arith_res == '0, 1'b0, arith_h, c_in};
      end
      OP_DEC: begin
        acc_o    = arith_res;
        acc_we_o = 1'b1;
        nf       = {arith_res == '0, 1'b1, arith_h, c_in};
      end
      OP_PAIR: begin
        pair_we_o = 1'b1;
        nf        = {flags_i[FZ], 1'b0, pair_h, pair_c};
      end
      default: ;
    endcase
  end

  assign flags_o = {nf, 4'b0000};
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
  input logic [3:0]  op_i,
  input logic [7:0]  flags_i,
  input logic [7:0]  acc_o,
  input logic [7:0]  flags_o,
  input logic        acc_we_o,
  input logic        pair_we_o
);
  always_comb begin
    a_r9_low_nibble_zero: assert (flags_o[3:0] == 4'b0000)
      else $error("low flag nibble not zero");
    a_r11_one_strobe: assert ($onehot0({acc_we_o, pair_we_o}))
      else $error("both strobes high");
    if (op_i <= 4'd9) begin
      a_r1_zero_tracks_result: assert (flags_o[7] == (acc_o == 8'h00))
        else $error("Z does not match byte result");
    end
    if (op_i == 4'd7) begin
      a_r4_cmp_no_write: assert (!acc_we_o)
        else $error("compare wrote accumulator");
    end
    if (op_i == 4'd4) begin
      a_r5_and_flags: assert (flags_o[6:4] == 3'b010)
        else $error("AND flags wrong");
    end
    if (op_i == 4'd5 || op_i == 4'd6) begin
      a_r6_xor_or_flags: assert (flags_o[6:4] == 3'b000)
        else $error("XOR/OR flags wrong");
    end
    if (op_i == 4'd8 || op_i == 4'd9) begin
      a_r7_incdec_keep_c: assert (flags_o[4] == flags_i[4])
        else $error("inc/dec changed C");
    end
    if (op_i == 4'd10) begin
      a_r8_pair_keep_z: assert (flags_o[7] == flags_i[7] && !flags_o[6])
        else $error("pair add Z/N wrong");
    end
    if (op_i > 4'd10) begin
      a_r10_unused_quiet: assert (!acc_we_o && !pair_we_o && flags_o[7:4] == flags_i[7:4])
        else $error("unused op had an effect");
    end
  end
endmodule

bind acc_alu acc_alu_chk chk_i (
  .op_i      (op_i),
  .flags_i   (flags_i),
  .acc_o     (acc_o),
  .flags_o   (flags_o),
  .acc_we_o  (acc_we_o),
  .pair_we_o (pair_we_o)
);

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
  logic        clk;
  logic [3:0]  op;
  logic [7:0]  acc, opnd, flg;
  logic [15:0] pl, pr;
  logic [7:0]  acc_o, flags_o;
  logic        acc_we, pair_we;
  logic [15:0] pair_o;
  int          n_chk, n_bad;
  bit          done;
  logic [31:0] lcg;

  acc_alu dut_i (
    .op_i(op), .acc_i(acc), .opnd_i(opnd), .flags_i(flg),
    .pair_l_i(pl), .pair_r_i(pr),
    .acc_o(acc_o), .flags_o(flags_o), .acc_we_o(acc_we),
    .pair_o(pair_o), .pair_we_o(pair_we)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] step(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic check(input string req, input logic [7:0] e_acc, input logic [7:0] e_flg,
                       input logic e_we, input logic e_pwe, input logic [15:0] e_pair);
    n_chk++;
    if (acc_we !== e_we || pair_we !== e_pwe || flags_o !== e_flg ||
        (e_we && acc_o !== e_acc) || (e_pwe && pair_o !== e_pair)) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h f=%h: got acc=%h f=%h we=%b pwe=%b pair=%h exp acc=%h f=%h we=%b pwe=%b pair=%h",
               req, op, acc, opnd, flg, acc_o, flags_o, acc_we, pair_we, pair_o,
               e_acc, e_flg, e_we, e_pwe, e_pair);
    end
  endtask

  // reference model computed from the requirements
  task automatic ref_byte(output string req, output logic [7:0] r, output logic [7:0] f,
                          output logic we);
    int a, b, c, s;
    bit z, n, h, cy;
    a = acc; b = opnd; c = flg[4];
    z = flg[7]; n = flg[6]; h = flg[5]; cy = flg[4];
    r = acc; we = 1'b0;
    case (op)
      0, 1: begin
        req = (op == 1) ? "R1/R3 adc" : "R1 add";
        if (op == 0) c = 0;
        s = a + b + c; r = s[7:0]; we = 1;
        z = (r == 0); n = 0; h = ((a % 16) + (b % 16) + c) > 15; cy = s > 255;
      end
      2, 3, 7: begin
        req = (op == 3) ? "R2/R3 sbc" : (op == 7) ? "R4 cmp" : "R2 sub";
        if (op != 3) c = 0;
        s = a - b - c; r = s[7:0]; we = (op != 7);
        z = (r == 0); n = 1; h = (a % 16) < (b % 16) + c; cy = s < 0;
      end
      4: begin req = "R5 and"; r = acc & opnd; we = 1; z = (r == 0); n = 0; h = 1; cy = 0; end
      5: begin req = "R6 xor"; r = acc ^ opnd; we = 1; z = (r == 0); n = 0; h = 0; cy = 0; end
      6: begin req = "R6 or";  r = acc | opnd; we = 1; z = (r == 0); n = 0; h = 0; cy = 0; end
      8: begin
        req = "R7 inc"; s = a + 1; r = s[7:0]; we = 1;
        z = (r == 0); n = 0; h = (a % 16) == 15;
      end
      9: begin
        req = "R7 dec"; s = a - 1; r = s[7:0]; we = 1;
        z = (r == 0); n = 1; h = (a % 16) == 0;
      end
      default: req = "R10 unused";
    endcase
    f = {z, n, h, cy, 4'b0000};
  endtask

  initial begin
    string       rq;
    logic [7:0]  er, ef;
    logic        ew;
    n_chk = 0; n_bad = 0; done = 0; lcg = 32'h1234_5678;
    op = 4'd15; acc = 8'h00; opnd = 8'h00; flg = 8'hFF; pl = '0; pr = '0;
    #1;
    // idle state, unused code: R9 low nibble masked, R10 no effect
    check("R9/R10 idle", 8'h00, 8'hF0, 1'b0, 1'b0, 16'h0);

    // R3 explicit corner: 0x0F + 0xFF + carry -> 0x0F, H=1, C=1
    op = 4'd1; acc = 8'h0F; opnd = 8'hFF; flg = 8'h10; #0.2;
    check("R3 adc ff+cin", 8'h0F, 8'h30, 1'b1, 1'b0, 16'h0);
    // R3 sbc corner: 0x00 - 0xFF - 1 -> 0x00, Z N H C all set
    op = 4'd3; acc = 8'h00; opnd = 8'hFF; flg = 8'h10; #0.2;
    check("R3 sbc ff+bin", 8'h00, 8'hF0, 1'b1, 1'b0, 16'h0);

    // R1..R11 byte ops, exhaustive over operand pairs
    for (int o = 0; o < 16; o++) begin
      if (o == 10) continue;
      for (int cv = 0; cv < 2; cv++) begin
        if (cv == 1 && !(o == 1 || o == 3 || o == 8 || o == 9)) continue;
        for (int a = 0; a < 256; a++) begin
          for (int b = 0; b < 256; b++) begin
            if (o > 10 && b > 3) continue;
            lcg = step(lcg);
            op = 4'(o); acc = 8'(a); opnd = 8'(b);
            flg = {lcg[23:21], (cv == 1) ? 1'b1 : ((o==1||o==3||o==8||o==9) ? 1'b0 : lcg[20]), lcg[3:0]};
            #0.2;
            ref_byte(rq, er, ef, ew);
            check(rq, er, ef, ew, 1'b0, 16'h0);
          end
        end
      end
    end

    // R8 pair add with half carry from bit 11 and carry from bit 15
    op = 4'd10;
    pl = 16'h0FFF; pr = 16'h0001; flg = 8'h80; #0.2;
    check("R8 pair h11", 8'h00, 8'hA0, 1'b0, 1'b1, 16'h1000);
    pl = 16'hFFFF; pr = 16'h0001; flg = 8'h4F; #0.2;
    check("R8 pair wrap", 8'h00, 8'h30, 1'b0, 1'b1, 16'h0000);
    for (int i = 0; i < 60000; i++) begin
      int s, hs;
      lcg = step(lcg); pl = lcg[31:16];
      lcg = step(lcg); pr = lcg[31:16]; flg = lcg[15:8];
      s = pl + pr; hs = (pl % 4096) + (pr % 4096);
      #0.2;
      check("R8 pair", 8'h00, {flg[7], 1'b0, hs > 4095, s > 65535, 4'b0000},
            1'b0, 1'b1, s[15:0]);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule